// File: doc/BRIEF.md
# Timer Tick Prescale and Divide Stage

This block turns the peripheral bus clock into count-enable ticks for five timer channels. Two 8-bit prescalers divide the bus clock by their programmed value plus one. Channels 0 and 1 share the first prescaler. Channels 2, 3 and 4 share the second.

Each channel has a 4-bit selector. The selector picks 1/2, 1/4, 1/8 or 1/16 of its group's prescaler rate, or it picks an external clock input. Each group has its own external clock input. That input goes through a two-flop synchronizer, and every rising edge becomes one tick.

Every tick is a one-cycle enable pulse in the bus clock domain, so the timer channels that follow it never need a second clock. A new prescaler value takes effect only at that prescaler's next terminal count. This keeps the tick in progress clean.

Top module: `tmr_tick_gen`

## Requirements
- R1: While `rst` is high, all `tick` bits are 0. The prescale and divide counts restart from zero when reset is released.
- R2: `presc_cfg[7:0]` sets the prescaler for channels 0 and 1. `presc_cfg[15:8]` sets the prescaler for channels 2, 3 and 4. Changing one byte does not alter the rate of the other group.
- R3: A prescaler value P (0 to 255) gives a prescaler output pulse every P+1 bus clock cycles.
- R4: Channel c reads its selector from `div_cfg[4c+3:4c]`. Selector codes 0, 1, 2 and 3 give a tick every (P+1)*2, (P+1)*4, (P+1)*8 and (P+1)*16 cycles.
- R5: Selector codes 5 to 15 act as code 0 (divide by 2).
- R6: Selector code 4 makes the channel tick once per rising edge of its group's external clock, after a two-flop synchronizer. `ext_clk_a` serves channels 0 and 1. `ext_clk_b` serves channels 2 to 4. The other group's external input has no effect.
- R7: A prescaler value written while that prescaler is counting is used only after its current period ends. The first tick gap after the change equals the rest of the old period plus the new spacing.
- R8: Every tick is high for exactly one bus clock cycle while the selector is unchanged.
- R9: With P = 99 and selector 3, a channel ticks every 1600 cycles. At a 50 MHz bus clock this is 31250 Hz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_cfg | input | 16 | Prescaler values: low byte for group A, high byte for group B |
| div_cfg | input | 20 | Per-channel 4-bit selectors; channel c at bits [4c+3:4c] |
| ext_clk_a | input | 1 | Asynchronous external clock for group A (channels 0 and 1) |
| ext_clk_b | input | 1 | Asynchronous external clock for group B (channels 2 to 4) |
| tick | output | 5 | One-cycle count-enable pulse for each channel |

## Verification
The hardest case to reach from the ports is a prescaler value changing partway through a period. A correct design must finish the old count before it uses the new one.

The bench waits for a tick on a running channel and rewrites that group's prescaler on the next falling edge. It then measures the next two gaps. The first gap must mix the old and new periods, and the second must be the new spacing.

The external input cases need care for another reason: a tick must not come from the wrong group's input. The bench toggles one external input with both groups in external mode, then counts the ticks on a channel of each group.

// File: rtl/tmr_tick_pkg.sv
package tmr_tick_pkg;

    localparam int SEL_W  = 4;
    localparam int DIV_W  = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_DIV2  = 4'd0,
        SEL_DIV4  = 4'd1,
        SEL_DIV8  = 4'd2,
        SEL_DIV16 = 4'd3,
        SEL_EXT   = 4'd4
    } tick_sel_e;

    // Decode a raw selector; undefined codes fall back to divide by 2 (R5)
    function automatic tick_sel_e decode_sel(input logic [SEL_W-1:0] raw);
        tick_sel_e s;
        case (raw)
            4'd1:    s = SEL_DIV4;
            4'd2:    s = SEL_DIV8;
            4'd3:    s = SEL_DIV16;
            4'd4:    s = SEL_EXT;
            default: s = SEL_DIV2;
        endcase
        return s;
    endfunction

    // True when the divider count is at the last step of the chosen ratio
    function automatic logic div_hit(input logic [DIV_W-1:0] cnt,
                                     input tick_sel_e sel);
        logic h;
        case (sel)
            SEL_DIV4:  h = &cnt[1:0];
            SEL_DIV8:  h = &cnt[2:0];
            SEL_DIV16: h = &cnt[3:0];
            default:   h = cnt[0];
        endcase
        return h;
    endfunction

endpackage

// File: rtl/tmr_presc_stage.sv
module tmr_presc_stage
    import tmr_tick_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] reload,
    output logic             pre_tick,
    output logic [DIV_W-1:0] div_cnt
);
    logic [PRE_W-1:0] cnt_q;

    assign pre_tick = (cnt_q == '0);

    // The reload value is sampled only at terminal count (R7)
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            div_cnt <= '0;
        end else begin
            if (pre_tick) begin
                cnt_q   <= reload;
                div_cnt <= div_cnt + 1'b1;
            end else begin
                cnt_q   <= cnt_q - 1'b1;
            end
        end
    end

    // R3: a nonzero reload leaves at least one idle cycle after a pulse
    assert_presc_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        (pre_tick && reload != '0) |=> !pre_tick);

    // R1: counts restart from zero after reset
    assert_presc_reset_R1: assert property (@(posedge clk)
        rst |=> (div_cnt == '0 && pre_tick));

endmodule

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync (
    input  logic clk,
    input  logic rst,
    input  logic ext_in,
    output logic ext_tick
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= ext_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign ext_tick = s2_q & ~s3_q;

    // R6: one rising edge gives exactly one pulse
    assert_ext_single_R6: assert property (@(posedge clk) disable iff (rst)
        ext_tick |=> !ext_tick);

endmodule

// File: rtl/tmr_chan_sel.sv
module tmr_chan_sel
    import tmr_tick_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_raw,
    input  logic             pre_tick,
    input  logic [DIV_W-1:0] div_cnt,
    input  logic             ext_tick,
    output logic             tick_q
);
    tick_sel_e sel;
    logic      src;

    always_comb begin
        sel = decode_sel(sel_raw);
        if (sel == SEL_EXT) src = ext_tick;
        else                src = pre_tick & div_hit(div_cnt, sel);
    end

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= src;
    end

    // R1: no tick right after a reset cycle
    assert_tick_reset_R1: assert property (@(posedge clk)
        rst |=> !tick_q);

    // R4: a divided tick follows a prescaler pulse
    assert_tick_from_presc_R4: assert property (@(posedge clk) disable iff (rst)
        (tick_q && $past(sel_raw) != 4'd4) |-> $past(pre_tick));

    // R6: an external-mode tick follows a synchronized edge
    assert_tick_from_ext_R6: assert property (@(posedge clk) disable iff (rst)
        (tick_q && $past(sel_raw) == 4'd4) |-> $past(ext_tick));

    // R8: single-cycle pulses while the selector is steady
    assert_tick_single_R8: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> (!tick_q || !$stable(sel_raw)));

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
    import tmr_tick_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int SPLIT  = 2,
    parameter int PRE_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [2*PRE_W-1:0]      presc_cfg,
    input  logic [NUM_CH*SEL_W-1:0] div_cfg,
    input  logic                    ext_clk_a,
    input  logic                    ext_clk_b,
    output logic [NUM_CH-1:0]       tick
);
    localparam int NUM_GRP = 2;

    logic [NUM_GRP-1:0]            grp_pre;
    logic [NUM_GRP-1:0][DIV_W-1:0] grp_div;
    logic [NUM_GRP-1:0]            grp_ext;
    logic [NUM_GRP-1:0]            ext_raw;

    assign ext_raw = {ext_clk_b, ext_clk_a};

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        tmr_presc_stage #(.PRE_W(PRE_W)) u_presc (
            .clk     (clk),
            .rst     (rst),
            .reload  (presc_cfg[g*PRE_W +: PRE_W]),
            .pre_tick(grp_pre[g]),
            .div_cnt (grp_div[g])
        );
        tmr_ext_sync u_sync (
            .clk     (clk),
            .rst     (rst),
            .ext_in  (ext_raw[g]),
            .ext_tick(grp_ext[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int GRP = (c < SPLIT) ? 0 : 1;   // R2 grouping
        tmr_chan_sel u_sel (
            .clk     (clk),
            .rst     (rst),
            .sel_raw (div_cfg[c*SEL_W +: SEL_W]),
            .pre_tick(grp_pre[GRP]),
            .div_cnt (grp_div[GRP]),
            .ext_tick(grp_ext[GRP]),
            .tick_q  (tick[c])
        );
    end

endmodule

// File: tb/tmr_tick_gen_tb.sv
module tmr_tick_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] presc_cfg = '0;
    logic [19:0] div_cfg = '0;
    logic        ext_clk_a = 1'b0;
    logic        ext_clk_b = 1'b0;
    logic [4:0]  tick;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    tmr_tick_gen u_dut (
        .clk(clk), .rst(rst), .presc_cfg(presc_cfg), .div_cfg(div_cfg),
        .ext_clk_a(ext_clk_a), .ext_clk_b(ext_clk_b), .tick(tick)
    );

    // Vector: {channel[2:0], prescaler[7:0], selector[3:0], period[15:0]}
    localparam int NV = 9;
    localparam logic [30:0] VEC [NV] = '{
        {3'd0, 8'd99,  4'd3,  16'd1600},  // R9, R4
        {3'd1, 8'd0,   4'd0,  16'd2},     // R3 minimum
        {3'd2, 8'd4,   4'd1,  16'd20},    // R2 group B
        {3'd3, 8'd255, 4'd2,  16'd2048},  // R3 maximum
        {3'd4, 8'd7,   4'd3,  16'd128},   // R2, R4
        {3'd0, 8'd2,   4'd7,  16'd6},     // R5
        {3'd2, 8'd0,   4'd15, 16'd2},     // R5
        {3'd1, 8'd5,   4'd2,  16'd48},    // R4
        {3'd3, 8'd1,   4'd0,  16'd4}      // R4
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic gap(input int ch, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick[ch] && n < 10000);
    endtask

    // Drive one external input with 'edges' rising edges, count ticks on two channels
    task automatic ext_run(input bit use_b, input int edges, input int cha,
                           input int chb, output int na, output int nb);
        na = 0; nb = 0;
        for (int i = 0; i < edges * 6 + 8; i++) begin
            @(negedge clk);
            if (i < edges * 6) begin
                if (use_b) ext_clk_b = ((i % 6) < 3);
                else       ext_clk_a = ((i % 6) < 3);
            end else begin
                ext_clk_a = 1'b0;
                ext_clk_b = 1'b0;
            end
            if (tick[cha]) na++;
            if (tick[chb]) nb++;
        end
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n, na, nb;

        // R1: no ticks while reset is held, even with fastest settings
        presc_cfg = 16'h0000;
        div_cfg   = '0;
        rst = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1 tick low in reset", tick, 0);
        end

        // Vector table: tick spacing per channel
        for (int v = 0; v < NV; v++) begin
            int ch, p, s, per;
            {ch, p, s, per} = {29'd0, VEC[v][30:28], 24'd0, VEC[v][27:20],
                               28'd0, VEC[v][19:16], 16'd0, VEC[v][15:0]};
            div_cfg = '0;
            div_cfg[ch*4 +: 4] = s[3:0];
            // other group's byte set to an unrelated value (R2)
            if (ch < 2) presc_cfg = {8'd37, p[7:0]};
            else        presc_cfg = {p[7:0], 8'd37};
            do_reset();
            gap(ch, n);
            gap(ch, n);
            check($sformatf("R3/R4 vec%0d ch%0d gap1", v, ch), n, per);
            gap(ch, n);
            check($sformatf("R8 vec%0d ch%0d gap2", v, ch), n, per);
        end

        // R7: prescaler change mid-period
        presc_cfg = {8'd37, 8'd9};
        div_cfg = '0;
        do_reset();
        gap(0, n);
        presc_cfg[7:0] = 8'd1;
        gap(0, n);
        check("R7 first gap after change", n, 12);
        gap(0, n);
        check("R7 settled gap", n, 4);

        // R2: changing group A byte leaves group B rate alone
        presc_cfg = {8'd3, 8'd0};
        div_cfg = '0;
        do_reset();
        gap(2, n);
        presc_cfg[7:0] = 8'd50;
        gap(2, n);
        check("R2 group B unaffected", n, 8);

        // R6: external clock per group
        presc_cfg = 16'hFFFF;
        div_cfg = '0;
        div_cfg[1*4 +: 4] = 4'd4;
        div_cfg[3*4 +: 4] = 4'd4;
        do_reset();
        ext_run(1'b0, 5, 1, 3, na, nb);
        check("R6 ext_a ticks on ch1", na, 5);
        check("R6 ext_a ignored by ch3", nb, 0);
        ext_run(1'b1, 4, 1, 3, na, nb);
        check("R6 ext_b ignored by ch1", na, 0);
        check("R6 ext_b ticks on ch3", nb, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule